// File: doc/BRIEF.md
# Banked Private Peripheral Address Decoder

This block sits in front of the 4 KB private register window of a cluster with several cores. Each bus request carries an address, a write flag, write data and the ID of the core that issued it. The decoder sends the request to one of three places. The first is a small snoop-control register set that it holds itself. The second is the interrupt-interface port of one core. The third is one of the timer instances, and each core has two of them: a timer and a watchdog. The interrupt-interface region and the timer region each have an alias that means "the core making this access". Each also has one explicit copy per core, spaced 0x100 apart.

Decoding is combinational. One-hot select lines, a local register offset and the passed-through write data go out in the cycle the request is presented. Read data from the chosen target is captured in that same cycle and returned one cycle later with an error flag. The block also turns the level interrupt from each timer instance into a single-cycle pulse. That pulse is aimed at the private interrupt input of the owning core.

Top module: `cluster_priv_decode`

## Requirements
- R1: After reset, resp_valid, resp_err, resp_data, scu_enable and ppi_pulse are all 0.
- R2: Offset 0x000 is the control register. A write there stores only bit 0 of the write data, and the stored bit drives scu_enable from the next cycle. A read there returns the stored bit in bit 0 and zeros above it.
- R3: Offset 0x004 reads 0x000000F3. Offsets 0x008 and 0x00C read 0. A write to 0x00C succeeds with no error and leaves the control register unchanged.
- R4: Any other access in 0x000–0x0FF gives resp_err=1 with resp_data=0 and asserts no select. This includes unaligned offsets and writes to 0x004 or 0x008.
- R5: Offsets 0x100–0x1FF assert gic_sel bit req_cpu. gic_offset equals address bits 7:0. fwd_write and fwd_wdata follow req_write and req_wdata.
- R6: Offsets 0x200 up to 0x200+NCPU×0x100 assert gic_sel bit (offset−0x200)>>8, whatever req_cpu is.
- R7: Offsets 0x600–0x6FF assert tmr_sel bit (req_cpu×2 + address bit 5), so bit 5 = 0 picks the timer and bit 5 = 1 picks the watchdog. tmr_offset equals address bits 3:0.
- R8: Offsets 0x700–0xAFF assert tmr_sel bit (((offset−0x700)>>8)×2 + address bit 5), whatever req_cpu is.
- R9: Offsets 0xB00–0xFFF assert no select. Reads return 0, writes have no effect, and resp_err stays 0.
- R10: Address bits above bit 11 have no effect on decode or response.
- R11: resp_valid is high exactly one cycle after req_valid. For a read, resp_data is the selected target's read data as sampled in the request cycle. For a write, resp_data is 0.
- R12: At most one bit across gic_sel and tmr_sel is high, and none is high without req_valid.
- R13: A rising edge on tmr_irq[i] gives a one-cycle pulse on ppi_pulse[i] in the next cycle. Bit i stands for private interrupt 29 + (i mod 2) of core i>>1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits 11:0 decoded |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | CPU_W | ID of the requesting core |
| resp_valid | output | 1 | Response valid, one cycle after request |
| resp_data | output | DATA_W | Registered read data |
| resp_err | output | 1 | Registered bad-address flag |
| fwd_write | output | 1 | Write flag toward targets |
| fwd_wdata | output | DATA_W | Write data toward targets |
| gic_sel | output | NCPU | One-hot interrupt-interface select |
| gic_offset | output | 8 | Interrupt-interface register offset |
| gic_rdata | input | NCPU×DATA_W | Read data, one slot per core |
| tmr_sel | output | 2×NCPU | One-hot timer-instance select |
| tmr_offset | output | 4 | Timer register offset |
| tmr_rdata | input | 2×NCPU×DATA_W | Read data, one slot per instance |
| tmr_irq | input | 2×NCPU | Level interrupt per timer instance |
| ppi_pulse | output | 2×NCPU | Rising-edge pulse per instance |
| scu_enable | output | 1 | Stored control bit |

## Verification
The assertions check the following on every cycle: select exclusivity, the one-cycle response timing, that scu_enable holds unless a control write occurred, that bad snoop-control accesses produce an error response with zero data, that the reserved range is error-free and reads zero, and the single-cycle shape of each edge pulse. The actual address-to-target mapping only shows in the bench's scenarios. These cover the own-core alias against the explicit banks for every core, the timer-versus-watchdog choice by bit 5, ignored high address bits, the snoop-control constants and write masking, and the returned read data of each target.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef enum logic [2:0] {
    RGN_SCU,
    RGN_GIC_SELF,
    RGN_GIC_BANK,
    RGN_TMR_SELF,
    RGN_TMR_BANK,
    RGN_RSVD
  } rgn_e;

  localparam logic [7:0]  SCU_OFF_CTRL  = 8'h00;
  localparam logic [7:0]  SCU_OFF_CFG   = 8'h04;
  localparam logic [7:0]  SCU_OFF_STAT  = 8'h08;
  localparam logic [7:0]  SCU_OFF_INVAL = 8'h0C;
  localparam logic [7:0]  SCU_CFG_VALUE = 8'hF3;

  localparam int WIN_BITS   = 12;
  localparam int BANK_SPAN  = 256;
  localparam int SCU_TOP    = 'h100;
  localparam int GIC_BANK0  = 'h200;

  // Timer instance index: owning core in the upper bits, watchdog flag below.
  function automatic int unsigned timer_index(int unsigned cpu, logic sel_wdog);
    return cpu * 2 + int'(sel_wdog);
  endfunction

endpackage

// File: rtl/cpd_region_dec.sv
module cpd_region_dec
  import cpd_pkg::*;
#(
  parameter  int NCPU   = 4,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int NTMR   = 2 * NCPU,
  localparam int TIDX_W = CPU_W + 1
) (
  input  logic                  req_valid,
  input  logic [WIN_BITS-1:0]   off,
  input  logic [CPU_W-1:0]      req_cpu,
  output rgn_e                  rgn,
  output logic [CPU_W-1:0]      tgt_cpu,
  output logic [TIDX_W-1:0]     tidx,
  output logic [NCPU-1:0]       gic_sel,
  output logic [NTMR-1:0]       tmr_sel
);

  localparam int TMR_SELF0 = GIC_BANK0 + NCPU * BANK_SPAN;
  localparam int TMR_BANK0 = TMR_SELF0 + BANK_SPAN;
  localparam int WIN_USED  = TMR_BANK0 + NCPU * BANK_SPAN;

  function automatic rgn_e classify(logic [WIN_BITS-1:0] a);
    int v;
    v = int'(a);
    if (v < SCU_TOP)         return RGN_SCU;
    else if (v < GIC_BANK0)  return RGN_GIC_SELF;
    else if (v < TMR_SELF0)  return RGN_GIC_BANK;
    else if (v < TMR_BANK0)  return RGN_TMR_SELF;
    else if (v < WIN_USED)   return RGN_TMR_BANK;
    else                     return RGN_RSVD;
  endfunction

  function automatic logic [CPU_W-1:0] bank_of(logic [WIN_BITS-1:0] a, int base);
    int d;
    d = (int'(a) - base) / BANK_SPAN;
    return CPU_W'(d);
  endfunction

  logic is_gic, is_tmr;

  always_comb begin
    rgn = classify(off);
    unique case (rgn)
      RGN_GIC_BANK: tgt_cpu = bank_of(off, GIC_BANK0);
      RGN_TMR_BANK: tgt_cpu = bank_of(off, TMR_BANK0);
      default:      tgt_cpu = req_cpu;
    endcase
    tidx   = TIDX_W'(timer_index(int'(tgt_cpu), off[5]));
    is_gic = req_valid && (rgn == RGN_GIC_SELF || rgn == RGN_GIC_BANK);
    is_tmr = req_valid && (rgn == RGN_TMR_SELF || rgn == RGN_TMR_BANK);
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_gic
    assign gic_sel[c] = is_gic && (tgt_cpu == CPU_W'(c));
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    assign tmr_sel[t] = is_tmr && (tidx == TIDX_W'(t));
  end

endmodule

// File: rtl/cpd_scu_regs.sv
module cpd_scu_regs
  import cpd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [7:0]        roff,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              bad,
  output logic              ctrl_we,
  output logic              ctrl_q
);

  logic rd_ok, wr_ok;

  always_comb begin
    rd_ok = (roff == SCU_OFF_CTRL) || (roff == SCU_OFF_CFG) ||
            (roff == SCU_OFF_STAT) || (roff == SCU_OFF_INVAL);
    wr_ok = (roff == SCU_OFF_CTRL) || (roff == SCU_OFF_INVAL);
    bad     = acc && (wr ? !wr_ok : !rd_ok);
    ctrl_we = acc && wr && (roff == SCU_OFF_CTRL);
    rdata   = '0;
    if (roff == SCU_OFF_CTRL)     rdata[0]   = ctrl_q;
    else if (roff == SCU_OFF_CFG) rdata[7:0] = SCU_CFG_VALUE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= wdata[0];
  end

endmodule

// File: rtl/cpd_resp_reg.sv
module cpd_resp_reg
  import cpd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  rgn_e              rgn,
  input  logic [DATA_W-1:0] scu_rdata,
  input  logic              scu_bad,
  input  logic [DATA_W-1:0] gic_pick,
  input  logic [DATA_W-1:0] tmr_pick,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_err
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (rgn)
      RGN_SCU:                    rd_mux = scu_bad ? '0 : scu_rdata;
      RGN_GIC_SELF, RGN_GIC_BANK: rd_mux = gic_pick;
      RGN_TMR_SELF, RGN_TMR_BANK: rd_mux = tmr_pick;
      default:                    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && scu_bad;
      resp_data  <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/cpd_ppi_edge.sv
module cpd_ppi_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);

  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[i]  <= 1'b0;
        pulse[i] <= 1'b0;
      end else begin
        prev[i]  <= lvl[i];
        pulse[i] <= lvl[i] && !prev[i];
      end
    end
  end

endmodule

// File: rtl/cluster_priv_decode.sv
module cluster_priv_decode
  import cpd_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  parameter  int NCPU   = 4,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int NTMR   = 2 * NCPU
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [CPU_W-1:0]       req_cpu,
  output logic                   resp_valid,
  output logic [DATA_W-1:0]      resp_data,
  output logic                   resp_err,
  output logic                   fwd_write,
  output logic [DATA_W-1:0]      fwd_wdata,
  output logic [NCPU-1:0]        gic_sel,
  output logic [7:0]             gic_offset,
  input  logic [NCPU*DATA_W-1:0] gic_rdata,
  output logic [NTMR-1:0]        tmr_sel,
  output logic [3:0]             tmr_offset,
  input  logic [NTMR*DATA_W-1:0] tmr_rdata,
  input  logic [NTMR-1:0]        tmr_irq,
  output logic [NTMR-1:0]        ppi_pulse,
  output logic                   scu_enable
);

  localparam int TIDX_W = CPU_W + 1;

  logic [WIN_BITS-1:0] off;
  rgn_e                rgn;
  logic [CPU_W-1:0]    tgt_cpu;
  logic [TIDX_W-1:0]   tidx;
  logic [DATA_W-1:0]   scu_rdata, gic_pick, tmr_pick;
  logic                scu_acc;

  // Named events for the checker.
  logic evt_scu_bad;
  logic evt_scu_wr_ctrl;
  logic evt_rsvd_hit;

  assign off        = req_addr[WIN_BITS-1:0];
  assign gic_offset = off[7:0];
  assign tmr_offset = off[3:0];
  assign fwd_write  = req_write;
  assign fwd_wdata  = req_wdata;
  assign scu_acc    = req_valid && (rgn == RGN_SCU);
  assign evt_rsvd_hit = req_valid && (rgn == RGN_RSVD);
  assign gic_pick   = gic_rdata[int'(tgt_cpu)*DATA_W +: DATA_W];
  assign tmr_pick   = tmr_rdata[int'(tidx)*DATA_W +: DATA_W];

  cpd_region_dec #(.NCPU(NCPU)) u_dec (
    .req_valid (req_valid),
    .off       (off),
    .req_cpu   (req_cpu),
    .rgn       (rgn),
    .tgt_cpu   (tgt_cpu),
    .tidx      (tidx),
    .gic_sel   (gic_sel),
    .tmr_sel   (tmr_sel)
  );

  cpd_scu_regs #(.DATA_W(DATA_W)) u_scu (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (scu_acc),
    .wr      (req_write),
    .roff    (off[7:0]),
    .wdata   (req_wdata),
    .rdata   (scu_rdata),
    .bad     (evt_scu_bad),
    .ctrl_we (evt_scu_wr_ctrl),
    .ctrl_q  (scu_enable)
  );

  cpd_resp_reg #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rgn        (rgn),
    .scu_rdata  (scu_rdata),
    .scu_bad    (evt_scu_bad),
    .gic_pick   (gic_pick),
    .tmr_pick   (tmr_pick),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .resp_err   (resp_err)
  );

  cpd_ppi_edge #(.N(NTMR)) u_ppi (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (tmr_irq),
    .pulse (ppi_pulse)
  );

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter  int DATA_W = 32,
  parameter  int NCPU   = 4,
  localparam int NTMR   = 2 * NCPU
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_data,
  input logic              resp_err,
  input logic [NCPU-1:0]   gic_sel,
  input logic [NTMR-1:0]   tmr_sel,
  input logic [NTMR-1:0]   tmr_irq,
  input logic [NTMR-1:0]   ppi_pulse,
  input logic              scu_enable,
  input logic              evt_scu_bad,
  input logic              evt_scu_wr_ctrl,
  input logic              evt_rsvd_hit
);

  assert_one_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gic_sel, tmr_sel}));

  assert_no_sel_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({gic_sel, tmr_sel} == '0));

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_ctrl_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_scu_wr_ctrl |=> $stable(scu_enable));

  assert_bad_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_scu_bad |=> (resp_err && resp_data == '0));

  assert_bad_no_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_scu_bad |-> ({gic_sel, tmr_sel} == '0));

  assert_err_with_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid);

  assert_rsvd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rsvd_hit |=> (resp_valid && !resp_err && resp_data == '0));

  for (genvar i = 0; i < NTMR; i++) begin : g_ppi
    assert_edge_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_irq[i]) |=> ppi_pulse[i]);
    assert_pulse_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ppi_pulse[i] |=> !ppi_pulse[i]);
  end

endmodule

bind cluster_priv_decode cpd_checker #(.DATA_W(DATA_W), .NCPU(NCPU)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .resp_valid      (resp_valid),
  .resp_data       (resp_data),
  .resp_err        (resp_err),
  .gic_sel         (gic_sel),
  .tmr_sel         (tmr_sel),
  .tmr_irq         (tmr_irq),
  .ppi_pulse       (ppi_pulse),
  .scu_enable      (scu_enable),
  .evt_scu_bad     (evt_scu_bad),
  .evt_scu_wr_ctrl (evt_scu_wr_ctrl),
  .evt_rsvd_hit    (evt_rsvd_hit)
);

// File: tb/cluster_priv_decode_test.sv
module cluster_priv_decode_test;

  localparam int NCPU = 4;
  localparam int NTMR = 8;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]     req_addr = '0, req_wdata = '0;
  logic [1:0]      req_cpu = '0;
  logic            resp_valid, resp_err, fwd_write, scu_enable;
  logic [31:0]     resp_data, fwd_wdata;
  logic [NCPU-1:0] gic_sel;
  logic [7:0]      gic_offset;
  logic [NCPU*DW-1:0] gic_rdata;
  logic [NTMR-1:0] tmr_sel, ppi_pulse;
  logic [NTMR-1:0] tmr_irq = '0;
  logic [3:0]      tmr_offset;
  logic [NTMR*DW-1:0] tmr_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit scu_shadow = 0;

  typedef struct { logic [31:0] d; logic e; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  // Target models: tagged read data per slot.
  always_comb begin
    for (int c = 0; c < NCPU; c++)
      gic_rdata[c*DW +: DW] = 32'hA000_0000 | (32'(c) << 16) | 32'(gic_offset);
    for (int t = 0; t < NTMR; t++)
      tmr_rdata[t*DW +: DW] = 32'hB000_0000 | (32'(t) << 16) | 32'(tmr_offset);
  end

  cluster_priv_decode uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err),
    .fwd_write(fwd_write), .fwd_wdata(fwd_wdata),
    .gic_sel(gic_sel), .gic_offset(gic_offset), .gic_rdata(gic_rdata),
    .tmr_sel(tmr_sel), .tmr_offset(tmr_offset), .tmr_rdata(tmr_rdata),
    .tmr_irq(tmr_irq), .ppi_pulse(ppi_pulse), .scu_enable(scu_enable)
  );

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one access, checks selects, pushes expected response.
  task automatic access(bit wr, logic [31:0] addr, logic [31:0] wd, logic [1:0] cpu);
    int o, bank, ti;
    logic [NCPU-1:0] eg;
    logic [NTMR-1:0] et;
    exp_t x;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd; req_cpu = cpu;
    #2;
    o = int'(addr[11:0]);
    eg = '0; et = '0; x.d = '0; x.e = 0;
    if (o < 'h100) begin
      x.tag = "R4";
      case (o)
        'h00: begin x.tag = "R2"; x.d = wr ? 0 : 32'(scu_shadow); end
        'h04: if (!wr) begin x.tag = "R3"; x.d = 32'hF3; end else x.e = 1;
        'h08: if (!wr) x.tag = "R3"; else x.e = 1;
        'h0C: x.tag = "R3";
        default: x.e = 1;
      endcase
      if (wr && o == 'h00) scu_shadow = wd[0];
    end else if (o < 'h600) begin
      bank = (o < 'h200) ? int'(cpu) : (o - 'h200) >> 8;
      x.tag = (o < 'h200) ? "R5" : "R6";
      eg[bank] = 1'b1;
      if (!wr) x.d = 32'hA000_0000 | (32'(bank) << 16) | 32'(addr[7:0]);
    end else if (o < 'hB00) begin
      bank = (o < 'h700) ? int'(cpu) : (o - 'h700) >> 8;
      ti = bank * 2 + int'(addr[5]);
      x.tag = (o < 'h700) ? "R7" : "R8";
      et[ti] = 1'b1;
      if (!wr) x.d = 32'hB000_0000 | (32'(ti) << 16) | 32'(addr[3:0]);
    end else x.tag = "R9";
    check(gic_sel == eg, x.tag, "gic_sel", 64'(gic_sel), 64'(eg));
    check(tmr_sel == et, x.tag, "tmr_sel", 64'(tmr_sel), 64'(et));
    if (eg != 0)
      check(gic_offset == addr[7:0] && fwd_write == wr && fwd_wdata == wd,
            "R5", "gic offset/fwd", {gic_offset, fwd_wdata}, {addr[7:0], wd});
    if (et != 0)
      check(tmr_offset == addr[3:0], "R7", "tmr_offset", 64'(tmr_offset), 64'(addr[3:0]));
    sb.push_back(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_write = 0;
    end
  endtask

  // Monitor: compares every response against the scoreboard (R11).
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) check(0, "R11", "unexpected response", 64'(resp_data), 64'h0);
      else begin
        exp_t x;
        x = sb.pop_front();
        check(resp_data == x.d && resp_err == x.e, x.tag, "response",
              {31'h0, resp_err, resp_data}, {31'h0, x.e, x.d});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(resp_valid == 0 && resp_err == 0 && resp_data == 0 && scu_enable == 0
          && ppi_pulse == 0, "R1", "reset state",
          {resp_valid, resp_err, scu_enable, ppi_pulse}, 64'h0);

    // Snoop-control block
    access(0, 32'h000, 0, 0);
    access(1, 32'h000, 32'hFFFF_FFFE, 0);
    access(1, 32'h000, 32'hFFFF_FFFF, 1);
    access(0, 32'h000, 0, 2);
    idle(1);
    check(scu_enable == 1, "R2", "scu_enable", 64'(scu_enable), 64'h1);
    access(0, 32'h004, 0, 0);
    access(0, 32'h008, 0, 0);
    access(0, 32'h00C, 0, 0);
    access(1, 32'h00C, 32'h0, 3);
    access(0, 32'h000, 0, 0);
    idle(1);
    check(scu_enable == 1, "R3", "inval write keeps ctrl", 64'(scu_enable), 64'h1);
    access(0, 32'h002, 0, 0);
    access(0, 32'h010, 0, 0);
    access(1, 32'h004, 32'h1, 0);
    access(1, 32'h008, 32'h1, 0);
    access(0, 32'h0FC, 0, 0);

    // Interrupt-interface alias and banks
    for (int c = 0; c < NCPU; c++) access(0, 32'h104 + 32'(c), 0, 2'(c));
    for (int c = 0; c < NCPU; c++) access(0, 32'h200 + 32'(c) * 32'h100 + 32'h18, 0, 2'(3 - c));
    access(1, 32'h1FC, 32'h1234_5678, 1);
    access(0, 32'h5FF, 0, 0);

    // Timers: alias and banks, timer and watchdog
    for (int c = 0; c < NCPU; c++) begin
      access(0, 32'h604, 0, 2'(c));
      access(0, 32'h628, 0, 2'(c));
    end
    for (int c = 0; c < NCPU; c++) begin
      access(0, 32'h700 + 32'(c) * 32'h100 + 32'h0C, 0, 0);
      access(0, 32'h720 + 32'(c) * 32'h100 + 32'h08, 0, 3);
    end
    access(1, 32'hAFF, 32'h55, 2);

    // Reserved and high address bits (R9, R10)
    access(0, 32'hB00, 0, 0);
    access(1, 32'hFFC, 32'hFFFF_FFFF, 1);
    access(0, 32'hFFF, 0, 3);
    access(0, 32'hDEAD_5104, 0, 1);
    access(0, 32'h1234_5824, 0, 0);
    access(0, 32'hFFFF_F004, 0, 0);
    idle(3);
    check(sb.size() == 0, "R11", "pending responses", 64'(sb.size()), 64'h0);

    // Edge pulses (R13)
    for (int i = 0; i < NTMR; i++) begin
      @(negedge clk); tmr_irq[i] = 1'b1;
      @(negedge clk);
      check(ppi_pulse == (NTMR'(1) << i), "R13", "pulse", 64'(ppi_pulse), 64'(NTMR'(1) << i));
      @(negedge clk);
      check(ppi_pulse == '0, "R13", "pulse width", 64'(ppi_pulse), 64'h0);
    end
    @(negedge clk); tmr_irq = '0;
    @(negedge clk);
    check(ppi_pulse == '0, "R13", "falling edge", 64'(ppi_pulse), 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule